// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the front end of one DMA channel. Software places a chain of 8-byte descriptors in memory and writes the chain's start address into a pair of list-pointer registers. Writing the low word arms the channel. The walker reads each descriptor as two 32-bit words, extracts a buffer address and a byte length, and hands that pair to a separate data mover through a request/done handshake. It then steps to the next descriptor, 8 bytes further on, until it has served the descriptor flagged as the end of the chain. At that point it emits a one-cycle completion pulse for the interrupt logic. Moving the payload itself is left to the data mover.

A receive-side channel (parameter `IS_RX` = 1) runs only while its enable register bit is 1. Clearing that bit in the middle of a chain abandons the chain. A transmit-side channel ignores the enable bit. A receive channel also carries a bytes-per-row value. The walker captures it when the chain starts and presents it next to every request, for line-oriented transfers. A descriptor with its valid flag clear, or a transfer entry whose length is not a whole number of 32-bit words, stops the walk and raises a sticky error flag.

The control flow is a state machine with seven states:
- `ST_IDLE`: waiting for a low-word write.
- `ST_ARM`: pointer loaded, waiting for the run permission.
- `ST_RD_LO` and `ST_RD_HI`: fetching the first and second descriptor word.
- `ST_CHECK`: decoding the descriptor.
- `ST_XFER`: a transfer request is outstanding.
- `ST_DONE`: the completion pulse.

The transitions are:
- IDLE→ARM on a low-word write.
- ARM→RD_LO once running is permitted.
- RD_LO→RD_HI and RD_HI→CHECK on a read response.
- CHECK→XFER for a transfer entry with a nonzero, word-multiple length.
- CHECK→RD_LO for a skipped entry that is not last.
- CHECK→DONE for a skipped entry that is last.
- CHECK→IDLE on an error.
- XFER→RD_LO or XFER→DONE on transfer done.
- DONE→IDLE.
- Any of RD_LO, RD_HI, CHECK or XFER returns to IDLE when running is withdrawn.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset the block is in idle: `mem_rd_req`, `xfer_req`, `chain_done`, `err_invalid` and `err_length` are all 0.
- R2: A write strobe on `cfg_lst_lo_we` while idle loads the list pointer from `cfg_lst_lo`. The first descriptor read goes to exactly that address, and `cfg_lst_hi` has no effect on it, even when nonzero.
- R3: Each descriptor is read as two words: the word at the pointer and then the word at pointer+4. The next descriptor is fetched from pointer+8.
- R4: The descriptor format is little-endian. In the first word, bit 0 is valid, bit 1 is end-of-chain, bit 5 is transfer, and bits 31:16 are the length. The second word is the buffer address. A valid transfer entry with a nonzero length that is a multiple of 4 raises `xfer_req` with that address and length, held stable until `xfer_done`.
- R5: A valid entry whose transfer bit is clear, or whose length is zero, issues no request. The walk continues, or completes if that entry is last.
- R6: When the end-of-chain entry has been served (its transfer done, or the entry skipped), `chain_done` is high for exactly one cycle and the walker returns to idle.
- R7: A fetched descriptor with the valid bit clear sets `err_invalid`, issues no request, produces no completion pulse, and returns the walker to idle.
- R8: A transfer entry whose length is not a multiple of 4 sets `err_length`, issues no request, produces no completion pulse, and returns the walker to idle.
- R9: Both error flags hold their value until the next accepted start, which clears them.
- R10: On a receive channel, an armed walker issues no read while `cfg_run_en` is 0 and starts fetching once it becomes 1.
- R11: On a receive channel, `cfg_run_en` falling to 0 during a walk drops `mem_rd_req` and `xfer_req` on the next cycle with no completion pulse. The walk does not resume when the enable returns.
- R12: A low-word write while the walker is not idle is ignored, and the running chain continues from its own pointer.
- R13: `cfg_row_bytes` is captured when the chain starts and is presented unchanged on `xfer_row_bytes` with every request of that chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lst_hi | input | 32 | High list-pointer word (ignored) |
| cfg_lst_lo | input | 32 | Low list-pointer word, chain start address |
| cfg_lst_lo_we | input | 1 | Write strobe of the low word; starts a chain when idle |
| cfg_run_en | input | 1 | Receive enable bit |
| cfg_row_bytes | input | ROW_W | Bytes-per-row setting |
| mem_rd_req | output | 1 | Descriptor read request, held until `mem_rd_valid` |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid, accepts the request |
| mem_rd_data | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the request |
| xfer_len | output | 16 | Byte length of the request |
| xfer_row_bytes | output | ROW_W | Row length captured at chain start |
| xfer_done | input | 1 | Data mover completion, ends the request |
| chain_done | output | 1 | One-cycle end-of-chain pulse |
| err_invalid | output | 1 | Sticky: descriptor with valid flag clear |
| err_length | output | 1 | Sticky: transfer length not a word multiple |

## Verification
The bench builds the walker with `IS_RX` = 1 and `ROW_W` = 16. This puts the enable gate in circuit, so the armed-but-waiting state and the mid-walk abort can both be driven from the ports. The 16-bit row width lets a captured row value be told apart from a value changed during the walk. A memory model with a fixed read latency and a data mover with an adjustable completion delay make the request and read hold windows long. That long window is what allows a low-word write to land while a transfer is outstanding, and an enable drop to land while the request is still open.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int DW         = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;

    localparam int FLAG_VALID = 0;
    localparam int FLAG_LAST  = 1;
    localparam int FLAG_XFER  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD_LO,
        ST_RD_HI,
        ST_CHECK,
        ST_XFER,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic             valid;
        logic             xfer;
        logic             last;
        logic             issue;
        logic [LEN_W-1:0] len;
        logic [DW-1:0]    addr;
    } desc_fields_t;

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
    import sgw_pkg::*;
(
    input  logic [DW-1:0] word_lo_i,
    input  logic [DW-1:0] word_hi_i,
    output desc_fields_t  fields_o,
    output logic          len_bad_o
);

    logic [7:0] flags;
    logic       unused_bits;

    assign flags = word_lo_i[7:0];

    always_comb begin
        fields_o.valid = flags[FLAG_VALID];
        fields_o.last  = flags[FLAG_LAST];
        fields_o.xfer  = flags[FLAG_XFER];
        fields_o.len   = word_lo_i[DW-1 -: LEN_W];
        fields_o.addr  = word_hi_i;
        fields_o.issue = fields_o.valid && fields_o.xfer && (fields_o.len != '0);
    end

    // R8: a transfer length must be a whole number of 32-bit words
    assign len_bad_o = fields_o.issue && (fields_o.len[1:0] != 2'b00);

    assign unused_bits = ^{flags[7:6], flags[4:2], word_lo_i[15:8]};

endmodule

// File: rtl/sgw_ptr_unit.sv
module sgw_ptr_unit
    import sgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          adv_i,
    input  logic          sel_hi_i,
    output logic [AW-1:0] rd_addr_o
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);
    localparam logic [AW-1:0] HALF = AW'(WORD_BYTES);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= load_val_i;
        end else if (adv_i) begin
            ptr_q <= ptr_q + STEP;
        end
    end

    assign rd_addr_o = ptr_q + (sel_hi_i ? HALF : '0);

    // R3: the next descriptor sits one descriptor size further on
    a_r3_advance_by_desc: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (ptr_q == $past(ptr_q) + STEP));

endmodule

// File: rtl/sgw_run_gate.sv
module sgw_run_gate #(
    parameter bit IS_RX = 1'b1
) (
    input  logic run_en_i,
    output logic run_ok_o
);

    generate
        if (IS_RX) begin : g_rx
            assign run_ok_o = run_en_i;
        end else begin : g_tx
            logic unused_en;
            assign unused_en = run_en_i;
            assign run_ok_o  = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int ROW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        cfg_lst_hi,
    input  logic [31:0]        cfg_lst_lo,
    input  logic               cfg_lst_lo_we,
    input  logic               cfg_run_en,
    input  logic [ROW_W-1:0]   cfg_row_bytes,
    output logic               mem_rd_req,
    output logic [31:0]        mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [31:0]        mem_rd_data,
    output logic               xfer_req,
    output logic [31:0]        xfer_addr,
    output logic [15:0]        xfer_len,
    output logic [ROW_W-1:0]   xfer_row_bytes,
    input  logic               xfer_done,
    output logic               chain_done,
    output logic               err_invalid,
    output logic               err_length
);

    walk_state_e  st_q, st_d;
    logic         run_ok;
    logic         start_ok;
    logic         walking;
    logic         ptr_adv;
    logic [DW-1:0] word_lo_q, word_hi_q;
    desc_fields_t dsc;
    logic         len_bad;
    logic [DW-1:0] xaddr_q;
    logic [LEN_W-1:0] xlen_q;
    logic [ROW_W-1:0] row_q;
    logic         err_inv_q, err_len_q;
    logic         unused_hi;

    // R2: addressing is 32-bit only, the high pointer word is dropped
    assign unused_hi = ^cfg_lst_hi;

    sgw_run_gate #(.IS_RX(IS_RX)) u_gate (
        .run_en_i (cfg_run_en),
        .run_ok_o (run_ok)
    );

    sgw_ptr_unit #(.AW(DW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok),
        .load_val_i (cfg_lst_lo),
        .adv_i      (ptr_adv),
        .sel_hi_i   (st_q == ST_RD_HI),
        .rd_addr_o  (mem_rd_addr)
    );

    sgw_desc_decode u_dec (
        .word_lo_i (word_lo_q),
        .word_hi_i (word_hi_q),
        .fields_o  (dsc),
        .len_bad_o (len_bad)
    );

    assign start_ok = (st_q == ST_IDLE) && cfg_lst_lo_we;
    assign walking  = (st_q == ST_RD_LO) || (st_q == ST_RD_HI) ||
                      (st_q == ST_CHECK) || (st_q == ST_XFER);

    assign ptr_adv = run_ok && !dsc.last &&
                     (((st_q == ST_CHECK) && dsc.valid && !dsc.issue) ||
                      ((st_q == ST_XFER) && xfer_done));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cfg_lst_lo_we) st_d = ST_ARM;
            ST_ARM:   if (run_ok) st_d = ST_RD_LO;
            ST_RD_LO: begin
                if (!run_ok)           st_d = ST_IDLE;
                else if (mem_rd_valid) st_d = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (!run_ok)           st_d = ST_IDLE;
                else if (mem_rd_valid) st_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!run_ok || !dsc.valid) st_d = ST_IDLE;
                else if (dsc.issue)        st_d = len_bad ? ST_IDLE : ST_XFER;
                else if (dsc.last)         st_d = ST_DONE;
                else                       st_d = ST_RD_LO;
            end
            ST_XFER: begin
                if (!run_ok)        st_d = ST_IDLE;
                else if (xfer_done) st_d = dsc.last ? ST_DONE : ST_RD_LO;
            end
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers: fetched words, request fields, row length, errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_lo_q <= '0;
            word_hi_q <= '0;
            xaddr_q   <= '0;
            xlen_q    <= '0;
            row_q     <= '0;
            err_inv_q <= 1'b0;
            err_len_q <= 1'b0;
        end else begin
            if (start_ok) begin
                row_q     <= cfg_row_bytes;
                err_inv_q <= 1'b0;
                err_len_q <= 1'b0;
            end
            if ((st_q == ST_RD_LO) && mem_rd_valid) word_lo_q <= mem_rd_data;
            if ((st_q == ST_RD_HI) && mem_rd_valid) word_hi_q <= mem_rd_data;
            if ((st_q == ST_CHECK) && run_ok) begin
                if (!dsc.valid) begin
                    err_inv_q <= 1'b1;
                end else if (dsc.issue) begin
                    if (len_bad) err_len_q <= 1'b1;
                    xaddr_q <= dsc.addr;
                    xlen_q  <= dsc.len;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd_req     = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
        xfer_req       = (st_q == ST_XFER);
        chain_done     = (st_q == ST_DONE);
        xfer_addr      = xaddr_q;
        xfer_len       = xlen_q;
        xfer_row_bytes = row_q;
        err_invalid    = err_inv_q;
        err_length     = err_len_q;
    end

    // R4: request fields hold until the data mover reports done
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done && run_ok) |=>
            (xfer_req && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_row_bytes)));

    // R3: a descriptor read keeps its address until answered
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid && run_ok) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R8: no request ever carries a partial-word or zero length
    a_r8_len_words: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ((xfer_len[1:0] == 2'b00) && (xfer_len != '0)));

    // R6: completion pulse lasts exactly one cycle
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chain_done);

    // R11: withdrawing the run permission ends all requests next cycle
    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && walking) |=> (!mem_rd_req && !xfer_req && !chain_done));

    // R7: an invalid descriptor leaves no request or completion behind
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_invalid |-> (!xfer_req && !chain_done));

endmodule

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb_top;

    localparam int ROW_W   = 16;
    localparam int MEM_LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0]      cfg_lst_hi = '0;
    logic [31:0]      cfg_lst_lo = '0;
    logic             cfg_lst_lo_we = 1'b0;
    logic             cfg_run_en = 1'b1;
    logic [ROW_W-1:0] cfg_row_bytes = '0;
    logic             mem_rd_req;
    logic [31:0]      mem_rd_addr;
    logic             mem_rd_valid = 1'b0;
    logic [31:0]      mem_rd_data = '0;
    logic             xfer_req;
    logic [31:0]      xfer_addr;
    logic [15:0]      xfer_len;
    logic [ROW_W-1:0] xfer_row_bytes;
    logic             xfer_done = 1'b0;
    logic             chain_done;
    logic             err_invalid;
    logic             err_length;

    sg_chain_walker #(.IS_RX(1'b1), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_lst_hi(cfg_lst_hi), .cfg_lst_lo(cfg_lst_lo), .cfg_lst_lo_we(cfg_lst_lo_we),
        .cfg_run_en(cfg_run_en), .cfg_row_bytes(cfg_row_bytes),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_row_bytes(xfer_row_bytes), .xfer_done(xfer_done),
        .chain_done(chain_done), .err_invalid(err_invalid), .err_length(err_length)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem [64];
    logic [31:0] log_addr [32];
    logic [15:0] log_len [32];
    logic [15:0] log_row [32];
    int log_n = 0;
    int done_cnt = 0;
    int rcnt = 0;
    int xcnt = 0;
    int xfer_lat = 3;
    logic first_pend = 1'b0;
    logic [31:0] first_rd = '0;

    // Memory and data mover models, evaluated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0; rcnt = 0; xfer_done = 1'b0; xcnt = 0;
        end else begin
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0; rcnt = 0;
            end else if (mem_rd_req) begin
                if (first_pend) begin first_rd = mem_rd_addr; first_pend = 1'b0; end
                if (rcnt >= MEM_LAT) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem[mem_rd_addr[7:2]];
                end else rcnt++;
            end else rcnt = 0;

            if (xfer_done) begin
                xfer_done = 1'b0; xcnt = 0;
            end else if (xfer_req) begin
                if (xcnt >= xfer_lat) begin
                    xfer_done = 1'b1;
                    log_addr[log_n] = xfer_addr;
                    log_len[log_n]  = xfer_len;
                    log_row[log_n]  = xfer_row_bytes;
                    log_n++;
                end else xcnt++;
            end else xcnt = 0;

            if (chain_done) done_cnt++;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_desc(int base, int idx, logic [7:0] flags, logic [15:0] len, logic [31:0] addr);
        mem[(base >> 2) + 2*idx]     = {len, 8'h00, flags};
        mem[(base >> 2) + 2*idx + 1] = addr;
    endtask

    task automatic kick(logic [31:0] base);
        cfg_lst_lo    = base;
        cfg_lst_lo_we = 1'b1;
        first_pend    = 1'b1;
        step();
        cfg_lst_lo_we = 1'b0;
    endtask

    task automatic settle(int d0);
        for (int i = 0; i < 3000; i++) begin
            if (done_cnt > d0 || err_invalid || err_length) break;
            step();
        end
        step();
    endtask

    // Main chain: flags, length, address, expected to issue a request
    localparam logic [56:0] VECS [6] = '{
        {8'h21, 16'd16,     32'h8000_0000, 1'b1},
        {8'h01, 16'd8,      32'h0000_0001, 1'b0},
        {8'h21, 16'd0,      32'h9000_0000, 1'b0},
        {8'h21, 16'hFFFC,   32'hA000_0010, 1'b1},
        {8'h21, 16'd4,      32'h1234_5678, 1'b1},
        {8'h23, 16'h0100,   32'hCAFE_0000, 1'b1}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int d0, n0, k;
        for (int i = 0; i < 64; i++) mem[i] = '0;

        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset outputs", {27'd0, mem_rd_req, xfer_req, chain_done, err_invalid, err_length}, 32'd0);

        // R10 and R2: armed with enable low, nonzero high word ignored
        put_desc(32'hE0, 0, 8'h23, 16'd32, 32'h5555_0000);
        cfg_run_en = 1'b0;
        cfg_lst_hi = 32'hFFFF_FFFF;
        d0 = done_cnt; n0 = log_n;
        kick(32'hE0);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            if (mem_rd_req) k++;
            step();
        end
        check("R10 no read while disabled", k, 0);
        cfg_run_en = 1'b1;
        settle(d0);
        check("R2 first read at low word", first_rd, 32'h0000_00E0);
        check("R10 runs once enabled", log_n - n0, 1);
        check("R6 single-entry chain done", done_cnt - d0, 1);
        cfg_lst_hi = '0;

        // R4 R5 R6 R13: table-driven chain walk
        for (int i = 0; i < 6; i++)
            put_desc(32'h40, i, VECS[i][56:49], VECS[i][48:33], VECS[i][32:1]);
        cfg_row_bytes = 16'h0280;
        d0 = done_cnt; n0 = log_n;
        kick(32'h40);
        cfg_row_bytes = 16'h03C0;
        settle(d0);
        k = n0;
        for (int i = 0; i < 6; i++) begin
            if (VECS[i][0]) begin
                check("R4 request address", log_addr[k], VECS[i][32:1]);
                check("R4 request length", {16'd0, log_len[k]}, {16'd0, VECS[i][48:33]});
                check("R13 row bytes captured", {16'd0, log_row[k]}, 32'h0000_0280);
                k++;
            end
        end
        check("R5 skipped entries issue nothing", log_n - n0, 4);
        check("R6 one pulse per chain", done_cnt - d0, 1);
        check("R6 back to idle", {30'd0, mem_rd_req, xfer_req}, 32'd0);

        // R7: invalid descriptor after one good transfer
        put_desc(32'h80, 0, 8'h21, 16'd8, 32'h7777_0000);
        put_desc(32'h80, 1, 8'h20, 16'd8, 32'h6666_0000);
        d0 = done_cnt; n0 = log_n;
        kick(32'h80);
        settle(d0);
        check("R7 error flag set", {31'd0, err_invalid}, 32'd1);
        check("R7 only the first entry served", log_n - n0, 1);
        check("R7 no completion pulse", done_cnt - d0, 0);

        // R8 and R9: misaligned length, earlier error cleared by new start
        put_desc(32'hC0, 0, 8'h23, 16'd6, 32'h4444_0000);
        d0 = done_cnt; n0 = log_n;
        kick(32'hC0);
        settle(d0);
        check("R8 length error set", {31'd0, err_length}, 32'd1);
        check("R9 invalid flag cleared on start", {31'd0, err_invalid}, 32'd0);
        check("R8 no request issued", log_n - n0, 0);
        check("R8 no completion pulse", done_cnt - d0, 0);
        repeat (5) step();
        check("R9 length flag held", {31'd0, err_length}, 32'd1);

        // R12: low-word write during a transfer is ignored
        put_desc(32'h00, 0, 8'h21, 16'd8,  32'h1111_0000);
        put_desc(32'h00, 1, 8'h23, 16'd12, 32'h2222_0000);
        xfer_lat = 20;
        d0 = done_cnt; n0 = log_n;
        kick(32'h00);
        for (int i = 0; i < 100 && !xfer_req; i++) step();
        check("R9 length flag cleared on start", {31'd0, err_length}, 32'd0);
        kick(32'h40);
        settle(d0);
        check("R12 chain count kept", log_n - n0, 2);
        check("R12 second request from own chain", log_addr[n0 + 1], 32'h2222_0000);
        check("R12 one completion", done_cnt - d0, 1);

        // R11: enable dropped mid-transfer
        xfer_lat = 40;
        d0 = done_cnt; n0 = log_n;
        kick(32'h00);
        for (int i = 0; i < 100 && !xfer_req; i++) step();
        cfg_run_en = 1'b0;
        step();
        check("R11 requests dropped", {30'd0, mem_rd_req, xfer_req}, 32'd0);
        cfg_run_en = 1'b1;
        k = 0;
        for (int i = 0; i < 10; i++) begin
            if (mem_rd_req || xfer_req) k++;
            step();
        end
        check("R11 no resume", k, 0);
        check("R11 no completion", done_cnt - d0, 0);
        check("R11 nothing served", log_n - n0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule